// File: doc/BRIEF.md
# Auxiliary Core Reset Controller

This block lets a host processor start, restart, halt and reload a secondary processor core. The host reaches one four-bit control register through a plain register port (write enable, address, write data, combinational read data). From that register the block derives three things for the secondary core: its reset, a separate reset for the platform around it (the core together with its local memories), and the enable that gates the core clock. A constant reset-vector base is also exported, and the core reads its first stack pointer and start address from there after any reset.

Two of the control bits are one-shot requests. Writing a 1 starts a reset pulse of `PULSE_LEN` clock cycles, and the bit clears itself in hardware once the pulse ends. A third bit is a sticky hold that keeps the core in reset until software clears it, so new firmware can be loaded safely without disabling the clock to the local memories. The fourth bit enables the core clock. A platform reset leaves the enable and the hold untouched. Each pulse request is run by its own small state machine with two states. `PS_IDLE` is entered on system reset and moves to `PS_DRIVE` when a write requests the pulse. `PS_DRIVE` returns to `PS_IDLE` once its cycle counter reaches `PULSE_LEN-1`.

Control register layout at address `REG_ADDR`: bit 0 = hold, bit 1 = core pulse request, bit 2 = platform pulse request, bit 3 = clock enable, bits 31..4 = zero.

Top module: `aux_core_rst_ctrl`

## Requirements
- R1: After system reset the register reads 0, and `core_rst`, `plat_rst`, `core_clk_en` and `core_running` are all 0.
- R2: `core_clk_en` equals register bit 3. `core_running` is 1 exactly when bit 3 is 1 and `core_rst` is 0.
- R3: Writing 1 to bit 2 raises `plat_rst` from the cycle after the write for exactly `PULSE_LEN` cycles. Bit 2 reads 1 for those cycles and 0 afterwards.
- R4: Writing 1 to bit 1 raises `core_rst` for exactly `PULSE_LEN` cycles starting the cycle after the write, leaves `plat_rst` low, and bit 1 reads 1 for those cycles only.
- R5: Bit 0 is sticky. While it reads 1, `core_rst` is 1 and `core_running` is 0. Writing 0 to it releases the core.
- R6: `core_rst` is the OR of the bit 0 level, the bit 1 pulse and the bit 2 pulse. `plat_rst` follows the bit 2 pulse only.
- R7: A platform reset pulse changes neither the enable bit nor the hold bit.
- R8: Bits 31..4 read 0 and ignore writes. A write to any address other than `REG_ADDR` has no effect, and reads there return 0.
- R9: `vector_base` is the constant `VEC_BASE`, default 0x0018_0000.
- R10: Writing 1 to bit 1 or bit 2 while its own pulse is running does not lengthen that pulse. Writing 0 to either bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for `addr`, combinational |
| core_rst | output | 1 | Reset to the secondary core |
| plat_rst | output | 1 | Reset to the core's platform and local memories |
| core_clk_en | output | 1 | Clock enable for the secondary core |
| core_running | output | 1 | Core is clocked and out of reset |
| vector_base | output | DATA_W | Fixed base address the core reads its first vectors from |

## Verification
The case that is hardest to reach from the ports is a second request that lands on a pulse while that pulse is still running. It matters because a pulse that restarts would stretch a reset that software timed. The stimulus issues a platform request and then issues it again one cycle into the pulse. It then counts the high cycles of `plat_rst` and expects `PULSE_LEN`, not a longer run. A full sweep of all sixteen values of the low nibble, each written from a cleared register, covers every mix of hold, pulse and enable. It also shows that the enable and hold bits are still set after a platform pulse has finished.

// File: rtl/acrc_pkg.sv
package acrc_pkg;

    // Control register bit positions; the host software decodes these
    localparam int unsigned BIT_HOLD = 0;
    localparam int unsigned BIT_CORE = 1;
    localparam int unsigned BIT_PLAT = 2;
    localparam int unsigned BIT_EN   = 3;
    localparam int unsigned CTRL_W   = 4;

    // Index of each pulse generator in the generate array
    localparam int unsigned PIDX_CORE = 0;
    localparam int unsigned PIDX_PLAT = 1;
    localparam int unsigned N_PULSE   = 2;

    typedef enum logic {
        PS_IDLE  = 1'b0,
        PS_DRIVE = 1'b1
    } pulse_state_e;

endpackage

// File: rtl/acrc_pulse_fsm.sv
module acrc_pulse_fsm
    import acrc_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);

    localparam int unsigned CNT_W = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_LEN - 1);

    pulse_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: a request is taken only in PS_IDLE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            PS_IDLE: begin
                cnt_d = '0;
                if (fire) state_d = PS_DRIVE;
            end
            PS_DRIVE: begin
                if (cnt_q == CNT_LAST) begin
                    state_d = PS_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        active = (state_q == PS_DRIVE);
    end

endmodule

// File: rtl/acrc_ctrl_reg.sv
module acrc_ctrl_reg
    import acrc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CTRL_W-1:0] wr_ctrl,
    input  logic              core_pulse,
    input  logic              plat_pulse,
    output logic              fire_core,
    output logic              fire_plat,
    output logic              en_q,
    output logic              hold_q,
    output logic [DATA_W-1:0] rd_data
);

    logic hit, wr_hit;

    always_comb begin
        hit    = (addr == REG_ADDR);
        wr_hit = wr_en && hit;
    end

    // Level bits: enable and sticky hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            hold_q <= 1'b0;
        end else if (wr_hit) begin
            en_q   <= wr_ctrl[BIT_EN];
            hold_q <= wr_ctrl[BIT_HOLD];
        end
    end

    // One-shot requests; only a written 1 starts a pulse
    always_comb begin
        fire_core = wr_hit && wr_ctrl[BIT_CORE];
        fire_plat = wr_hit && wr_ctrl[BIT_PLAT];
    end

    // Readback: pulse bits show the running pulse
    always_comb begin
        rd_data = '0;
        if (hit) begin
            rd_data[BIT_HOLD] = hold_q;
            rd_data[BIT_CORE] = core_pulse;
            rd_data[BIT_PLAT] = plat_pulse;
            rd_data[BIT_EN]   = en_q;
        end
    end

endmodule

// File: rtl/aux_core_rst_ctrl.sv
module aux_core_rst_ctrl
    import acrc_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PULSE_LEN = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0,
    parameter logic [DATA_W-1:0] VEC_BASE = DATA_W'(32'h0018_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              core_rst,
    output logic              plat_rst,
    output logic              core_clk_en,
    output logic              core_running,
    output logic [DATA_W-1:0] vector_base
);

    logic [N_PULSE-1:0] fire, active;
    logic               en_q, hold_q;

    acrc_ctrl_reg #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .REG_ADDR (REG_ADDR)
    ) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_ctrl    (wr_data[CTRL_W-1:0]),
        .core_pulse (active[PIDX_CORE]),
        .plat_pulse (active[PIDX_PLAT]),
        .fire_core  (fire[PIDX_CORE]),
        .fire_plat  (fire[PIDX_PLAT]),
        .en_q       (en_q),
        .hold_q     (hold_q),
        .rd_data    (rd_data)
    );

    for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
        acrc_pulse_fsm #(
            .PULSE_LEN (PULSE_LEN)
        ) u_pulse (
            .clk    (clk),
            .rst_n  (rst_n),
            .fire   (fire[g]),
            .active (active[g])
        );
    end

    always_comb begin
        core_rst     = hold_q | active[PIDX_CORE] | active[PIDX_PLAT];
        plat_rst     = active[PIDX_PLAT];
        core_clk_en  = en_q;
        core_running = en_q & ~core_rst;
        vector_base  = VEC_BASE;
    end

endmodule

// File: rtl/acrc_checker.sv
module acrc_checker #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned PULSE_LEN = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              core_rst,
    input logic              plat_rst,
    input logic              core_clk_en,
    input logic              core_running,
    input logic              hold_q
);

    localparam int unsigned RUN_W = $clog2(PULSE_LEN + 2);

    logic [RUN_W-1:0] plat_run;
    logic             wr_hit;

    assign wr_hit = wr_en && (addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        plat_run <= '0;
        else if (plat_rst) plat_run <= plat_run + 1'b1;
        else               plat_run <= '0;
    end

    AST_PLAT_IN_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        plat_rst |-> core_rst); // R6

    AST_HELD_NOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hold_q |-> (core_rst && !core_running)); // R5

    AST_RUN_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        core_running |-> (core_clk_en && !core_rst)); // R2

    AST_PLAT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_data[2]) |=> plat_rst); // R3

    AST_PLAT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        plat_run <= RUN_W'(PULSE_LEN)); // R3

    AST_CORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_data[1]) |=> core_rst); // R4

    AST_PLAT_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (plat_rst && !wr_hit) |=> $stable(core_clk_en)); // R7

    AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:4] == '0); // R8

endmodule

bind aux_core_rst_ctrl acrc_checker #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PULSE_LEN (PULSE_LEN),
    .REG_ADDR  (REG_ADDR)
) u_acrc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .addr         (addr),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .core_rst     (core_rst),
    .plat_rst     (plat_rst),
    .core_clk_en  (core_clk_en),
    .core_running (core_running),
    .hold_q       (hold_q)
);

// File: tb/aux_core_rst_ctrl_bench.sv
module aux_core_rst_ctrl_bench;

    localparam int unsigned CLK_P  = 10;
    localparam int unsigned AW     = 4;
    localparam int unsigned DW     = 32;
    localparam int unsigned PL     = 4;
    localparam logic [DW-1:0] VEC  = 32'h0018_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data, vector_base;
    logic          core_rst, plat_rst, core_clk_en, core_running;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    aux_core_rst_ctrl #(
        .ADDR_W    (AW),
        .DATA_W    (DW),
        .PULSE_LEN (PL)
    ) u_aux_core_rst_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .core_rst     (core_rst),
        .plat_rst     (plat_rst),
        .core_clk_en  (core_clk_en),
        .core_running (core_running),
        .vector_base  (vector_base)
    );

    task automatic chk(input logic [DW-1:0] got, input logic [DW-1:0] exp,
                       input string req, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    // Drives at a negedge, returns at the negedge after the write edge
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(CLK_P * 100000);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int pc, cc;
        logic [3:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rd_data, '0, "R1", "reg in reset");
        chk({28'b0, core_rst, plat_rst, core_clk_en, core_running}, '0, "R1", "outputs in reset");
        rst_n = 1'b1;
        idle(1);
        chk(rd_data, '0, "R1", "reg after reset");
        // R9 vector base
        chk(vector_base, VEC, "R9", "vector base");

        // Sweep of the low nibble from a cleared register
        for (int k = 0; k < 16; k++) begin
            v = 4'(k);
            wr('0, '0);
            idle(PL + 2);
            wr('0, 32'(v));
            chk(rd_data, 32'(v), "R3 R4", $sformatf("readback v=%0d", k));
            chk(32'(core_rst), 32'(v[0] | v[1] | v[2]), "R6", $sformatf("core_rst v=%0d", k));
            chk(32'(plat_rst), 32'(v[2]), "R6", $sformatf("plat_rst v=%0d", k));
            chk(32'(core_clk_en), 32'(v[3]), "R2", $sformatf("clk_en v=%0d", k));
            chk(32'(core_running), 32'(v[3] & ~(v[0] | v[1] | v[2])), "R2",
                $sformatf("running v=%0d", k));
            pc = 0; cc = 0;
            for (int i = 0; i < PL + 2; i++) begin
                if (plat_rst) pc++;
                if (rd_data[1]) cc++;
                @(negedge clk);
            end
            chk(32'(pc), v[2] ? PL : 0, "R3", $sformatf("plat pulse len v=%0d", k));
            chk(32'(cc), v[1] ? PL : 0, "R4", $sformatf("core pulse len v=%0d", k));
            chk(rd_data, {28'b0, v[3], 2'b00, v[0]}, "R7", $sformatf("after pulse v=%0d", k));
            chk(32'(core_rst), 32'(v[0]), "R5", $sformatf("hold level v=%0d", k));
            chk(32'(core_running), 32'(v[3] & ~v[0]), "R2", $sformatf("run after v=%0d", k));
        end

        // R5 release the sticky hold
        wr('0, 32'h9);
        idle(2);
        chk(32'(core_running), 0, "R5", "held core not running");
        wr('0, 32'h8);
        chk(32'(core_rst), 0, "R5", "hold released");
        chk(32'(core_running), 1, "R5", "core runs after release");

        // R8 upper bits and foreign address
        wr('0, 32'hFFFF_FFF0);
        chk(rd_data, '0, "R8", "upper bits ignored");
        wr(4'h3, 32'h0000_000F);
        chk(32'(core_rst | plat_rst | core_clk_en), 0, "R8", "other addr no effect");
        addr = 4'h3;
        #1;
        chk(rd_data, '0, "R8", "other addr reads zero");
        addr = '0;
        #1;
        chk(rd_data, '0, "R8", "reg unchanged");

        // R10 repeated request does not stretch the pulse
        idle(1);
        wr('0, 32'h4);
        pc = plat_rst ? 1 : 0;
        wr('0, 32'h4);
        for (int i = 0; i < PL + 2; i++) begin
            if (plat_rst) pc++;
            @(negedge clk);
        end
        chk(32'(pc), PL, "R10", "plat pulse not extended");
        wr('0, 32'h2);
        cc = rd_data[1] ? 1 : 0;
        wr('0, 32'h2);
        for (int i = 0; i < PL + 2; i++) begin
            if (rd_data[1]) cc++;
            @(negedge clk);
        end
        chk(32'(cc), PL, "R10", "core pulse not extended");
        // R10 writing 0 mid-pulse does not cut it
        wr('0, 32'h4);
        wr('0, 32'h0);
        chk(32'(plat_rst), 1, "R10", "zero write keeps pulse");

        summary();
        $finish;
    end

endmodule